// File: doc/BRIEF.md
# Gated Four-Phase Light Sequencer

This block steps three groups of lights through a fixed, repeating four-step pattern. The pattern builds up: the first group lights alone, then the first and second groups, then all three, and then everything goes dark before the cycle starts again. The pattern advances by one step on every clock edge. A 2-bit state register holds the current step, and next-state logic computes the following step from it.

A main-switch input gates every light output. While the switch is off, all three outputs read 0. The state register keeps counting while the switch is off, so turning the switch back on shows whatever step the count has reached at that moment. The switch gating is purely combinational. A change on the switch reaches the outputs in the same cycle, and the next clock edge plays no part in it.

Top module: `lamp_cycler`

## Requirements
- R1: When `rst` is high at a rising edge of `clk`, the state becomes step 0 at that edge. Step 0 is encoding 00. Asserting `rst` does not change the outputs before that edge.
- R2: When `rst` is low at a rising edge, the state advances by one: 00 to 01 to 10 to 11, and 11 wraps to 00.
- R3: In step 01 with the switch on, only `lamp_a` is 1.
- R4: In step 10 with the switch on, `lamp_a` and `lamp_b` are 1 and `lamp_c` is 0.
- R5: In step 11 with the switch on, all three outputs are 1.
- R6: In step 00, all three outputs are 0.
- R7: While `sw_on` is 0, all three outputs are 0 whatever the step.
- R8: The state keeps advancing while `sw_on` is 0. When the switch returns, the outputs show the step reached by counting every edge since reset.
- R9: A change on `sw_on` reaches the outputs in the same clock cycle, with no register delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the state updates on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sw_on | input | 1 | Main switch; 1 lets the lights follow the step |
| lamp_a | output | 1 | Enable for light group 1 |
| lamp_b | output | 1 | Enable for light group 2 |
| lamp_c | output | 1 | Enable for light group 3 |

## Verification
The lamp outputs depend on the state register and the switch, with no register between the switch and the outputs. A step change therefore shows up just after the rising edge that causes it, and a switch change shows up as soon as the switch is driven. Reset takes effect only at the first edge where it is held high. The bench drives `rst` and `sw_on` 2 ns after each rising edge. It queues the value expected for that same cycle from a model that counts edges, and compares the outputs at the following falling edge. Every expectation therefore falls in the cycle where it is due.

// File: rtl/lamp_cycler.sv
module lamp_cycler (
  input  logic clk,
  input  logic rst,
  input  logic sw_on,
  output logic lamp_a,
  output logic lamp_b,
  output logic lamp_c
);
  localparam int SW = 2;
  localparam logic [SW-1:0] DARK = '0;
  localparam logic [SW-1:0] FULL = '1;

  logic [SW-1:0] phase;
  logic [SW-1:0] phase_nxt;

  assign phase_nxt = phase + SW'(1);

  always_ff @(posedge clk) begin
    if (rst) phase <= DARK;
    else     phase <= phase_nxt;
  end

  assign lamp_a = sw_on & (phase != DARK);
  assign lamp_b = sw_on & phase[SW-1];
  assign lamp_c = sw_on & (phase == FULL);
endmodule

// File: rtl/lamp_cycler_chk.sv
module lamp_cycler_chk (
  input logic       clk,
  input logic       rst,
  input logic       sw_on,
  input logic       lamp_a,
  input logic       lamp_b,
  input logic       lamp_c,
  input logic [1:0] phase
);
  AST_RESET_ZERO: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> phase == 2'd0); // R1

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
    !$fell(rst) |-> phase == $past(phase) + 2'd1); // R2

  AST_FIRST_ONLY: assert property (@(posedge clk) disable iff (rst)
    (sw_on && phase == 2'd1) |-> (lamp_a && !lamp_b && !lamp_c)); // R3

  AST_B_NEEDS_A: assert property (@(posedge clk) disable iff (rst)
    (lamp_b || lamp_c) |-> lamp_a); // R4

  AST_C_NEEDS_B: assert property (@(posedge clk) disable iff (rst)
    lamp_c |-> lamp_b); // R5

  AST_DARK_STEP: assert property (@(posedge clk) disable iff (rst)
    phase == 2'd0 |-> !(lamp_a || lamp_b || lamp_c)); // R6

  AST_SWITCH_MASK: assert property (@(posedge clk) disable iff (rst)
    !sw_on |-> !(lamp_a || lamp_b || lamp_c)); // R7
endmodule

bind lamp_cycler lamp_cycler_chk u_chk (
  .clk(clk), .rst(rst), .sw_on(sw_on),
  .lamp_a(lamp_a), .lamp_b(lamp_b), .lamp_c(lamp_c), .phase(phase)
);

// File: tb/sim_lamp_cycler.sv
module sim_lamp_cycler;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sw_on = 1'b1;
  logic lamp_a, lamp_b, lamp_c;

  typedef struct {
    logic [2:0] want;
    string      tag;
  } exp_t;

  exp_t sb[$];
  int checks = 0;
  int errors = 0;
  logic [1:0] model = 2'd0;
  bit done = 0;

  always #10 clk = ~clk;

  lamp_cycler u0 (
    .clk(clk), .rst(rst), .sw_on(sw_on),
    .lamp_a(lamp_a), .lamp_b(lamp_b), .lamp_c(lamp_c)
  );

  function automatic logic [2:0] pattern(input logic [1:0] p, input logic s);
    logic [2:0] v;
    case (p)
      2'd0: v = 3'b000;
      2'd1: v = 3'b001;
      2'd2: v = 3'b011;
      default: v = 3'b111;
    endcase
    return s ? v : 3'b000;
  endfunction

  task automatic cyc(input logic r, input logic s, input string tag);
    exp_t e;
    @(posedge clk);
    model = rst ? 2'd0 : model + 2'd1;
    #2;
    rst = r;
    sw_on = s;
    e.want = pattern(model, s);
    e.tag = tag;
    sb.push_back(e);
  endtask

  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      logic [2:0] got;
      e = sb.pop_front();
      got = {lamp_c, lamp_b, lamp_a};
      checks++;
      if (got !== e.want) begin
        errors++;
        $display("FAIL %s: lamps(c,b,a)=%b expected %b", e.tag, got, e.want);
      end
    end
  end

  initial begin
    cyc(1, 1, "R1");
    cyc(1, 1, "R1");
    cyc(0, 1, "R6");
    cyc(0, 1, "R3");
    cyc(0, 1, "R4");
    cyc(0, 1, "R5");
    cyc(0, 1, "R2");
    for (int i = 0; i < 8; i++) cyc(0, 1, "R2");
    cyc(0, 0, "R9");
    for (int i = 0; i < 6; i++) cyc(0, 0, "R7");
    cyc(0, 1, "R8");
    cyc(0, 1, "R8");
    cyc(0, 0, "R9");
    cyc(0, 1, "R9");
    cyc(1, 1, "R1");
    cyc(0, 1, "R1");
    cyc(0, 1, "R3");
    cyc(0, 0, "R7");
    cyc(0, 1, "R5");
    @(negedge clk);
    #1;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule